// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block turns the opcode field and the function field of a 32-bit instruction into the control lines of a single-cycle datapath. It is purely combinational. The first level reads only the 6-bit opcode. It produces the seven datapath steering and enable lines, plus a 2-bit ALU class that summarises what the arithmetic unit has to do. The second level takes that class and the 6-bit function field and produces a 4-bit ALU operation code.

Register-format instructions use opcode 0x00. Four of the arithmetic and logic function codes are recognised, together with set-on-less-than. Three other opcodes are supported: a word load, a word store and a branch on equal. Any other opcode decodes to a safe "no operation": every enable is low and the ALU code is 0000. A register-format opcode with an unknown function code is suppressed in the same way. A datapath that uses the block drives the two fields from the fetched instruction. It uses the outputs within the same cycle.

Top module: `ctl_decoder_top`

## Requirements
- R1: Opcode 0x00 with a known function code gives reg_dst=1 and reg_wr=1. It gives alu_src, mem_to_reg, mem_rd, mem_wr and branch all 0, and ALU class 2'b10.
- R2: Opcode 0x23 (load) gives alu_src=1, mem_to_reg=1, reg_wr=1 and mem_rd=1. It gives reg_dst, mem_wr and branch all 0, class 2'b00 and ALU code 4'b0010 (add).
- R3: Opcode 0x2B (store) gives alu_src=1 and mem_wr=1. All other control lines are 0, the class is 2'b00 and the ALU code is 4'b0010 (add).
- R4: Opcode 0x04 (branch on equal) gives branch=1. All other control lines are 0, the class is 2'b01 and the ALU code is 4'b0110 (subtract).
- R5: Under class 2'b10 the function field selects the ALU code as follows: 0x20→0010 (add), 0x22→0110 (subtract), 0x24→0000 (and), 0x25→0001 (or), 0x2A→0111 (set-on-less-than).
- R6: Any opcode other than 0x00, 0x23, 0x2B and 0x04 drives all seven control lines to 0, the class to 2'b11 and the ALU code to 4'b0000.
- R7: Opcode 0x00 with any function code not listed in R5 drives all seven control lines to 0 and the ALU code to 4'b0000. The class stays 2'b10.
- R8: For every opcode other than 0x00, the function field has no effect on any output.
- R9: Whenever a supported instruction is decoded, ALU code bit 2 equals class bit 0 OR (class bit 1 AND function bit 1).
- R10: At most one of mem_rd, mem_wr and branch is high, and reg_wr is never high together with mem_wr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_opcode | input | 6 | Instruction opcode field |
| i_funct | input | 6 | Instruction function field |
| o_reg_dst | output | 1 | Destination register taken from the rd field (1) or the rt field (0) |
| o_alu_src | output | 1 | Second ALU operand is the sign-extended immediate |
| o_mem_to_reg | output | 1 | Write-back data comes from memory rather than from the ALU |
| o_reg_wr | output | 1 | Register file write enable |
| o_mem_rd | output | 1 | Data memory read enable |
| o_mem_wr | output | 1 | Data memory write enable |
| o_branch | output | 1 | Instruction is a conditional branch |
| o_alu_cls | output | 2 | ALU class: 00 memory, 01 branch, 10 register format, 11 none |
| o_alu_code | output | 4 | ALU operation code |

## Verification
The bench sweeps all 4096 combinations of opcode and function field against a model written from the requirement tables.

- **Stray opcodes:** every unsupported opcode is covered. A decoder with a loose match, such as one that ignores the upper opcode bits, would assert writes for those opcodes.
- **Function field outside register format:** the function field varies under the load, store and branch opcodes. A second level that reads the function field regardless of class would then emit the wrong ALU code.
- **Unknown function codes under opcode 0x00:** a design that forgot to gate these would still write the register file with a meaningless ALU result.
- **Single-bit code differences:** the ALU codes add/subtract and and/or differ in one bit. A swapped or dropped bit therefore shows up directly in the code comparison.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int CLS_W = 2;
    localparam int ALU_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_MEM  = 2'b00,
        CLS_BR   = 2'b01,
        CLS_REG  = 2'b10,
        CLS_NONE = 2'b11
    } alu_cls_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_code_e;

    localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    typedef struct packed {
        logic reg_dst;
        logic alu_src;
        logic mem_to_reg;
        logic reg_wr;
        logic mem_rd;
        logic mem_wr;
        logic branch;
    } ctl_bits_t;

    localparam ctl_bits_t CTL_OFF = '0;

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
    import ctl_dec_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctl_bits_t       ctl,
    output alu_cls_e        cls
);

    always_comb begin
        ctl = CTL_OFF;
        cls = CLS_NONE;
        case (opcode)
            OPC_REG: begin
                ctl.reg_dst = 1'b1;
                ctl.reg_wr  = 1'b1;
                cls         = CLS_REG;
            end
            OPC_LOAD: begin
                ctl.alu_src    = 1'b1;
                ctl.mem_to_reg = 1'b1;
                ctl.reg_wr     = 1'b1;
                ctl.mem_rd     = 1'b1;
                cls            = CLS_MEM;
            end
            OPC_STORE: begin
                ctl.alu_src = 1'b1;
                ctl.mem_wr  = 1'b1;
                cls         = CLS_MEM;
            end
            OPC_BEQ: begin
                ctl.branch = 1'b1;
                cls        = CLS_BR;
            end
            default: begin
                ctl = CTL_OFF;
                cls = CLS_NONE;
            end
        endcase
    end

endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
    import ctl_dec_pkg::*;
(
    input  alu_cls_e         cls,
    input  logic [FN_W-1:0]  funct,
    output logic [ALU_W-1:0] code,
    output logic             legal
);

    logic [ALU_W-1:0] fn_code;
    logic             fn_known;

    always_comb begin
        fn_known = 1'b1;
        case (funct)
            FN_ADD:  fn_code = ALU_ADD;
            FN_SUB:  fn_code = ALU_SUB;
            FN_AND:  fn_code = ALU_AND;
            FN_OR:   fn_code = ALU_OR;
            FN_SLT:  fn_code = ALU_SLT;
            default: begin
                fn_code  = ALU_AND;
                fn_known = 1'b0;
            end
        endcase
    end

    always_comb begin
        unique case (cls)
            CLS_MEM: begin
                code  = ALU_ADD;
                legal = 1'b1;
            end
            CLS_BR: begin
                code  = ALU_SUB;
                legal = 1'b1;
            end
            CLS_REG: begin
                code  = fn_known ? fn_code : ALU_AND;
                legal = fn_known;
            end
            CLS_NONE: begin
                code  = ALU_AND;
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ctl_decoder_top.sv
module ctl_decoder_top
    import ctl_dec_pkg::*;
(
    input  logic [5:0] i_opcode,
    input  logic [5:0] i_funct,
    output logic       o_reg_dst,
    output logic       o_alu_src,
    output logic       o_mem_to_reg,
    output logic       o_reg_wr,
    output logic       o_mem_rd,
    output logic       o_mem_wr,
    output logic       o_branch,
    output logic [1:0] o_alu_cls,
    output logic [3:0] o_alu_code
);

    ctl_bits_t        main_ctl;
    ctl_bits_t        gated_ctl;
    alu_cls_e         main_cls;
    logic [ALU_W-1:0] alu_code;
    logic             alu_legal;

    ctl_main_dec u_main (
        .opcode (i_opcode),
        .ctl    (main_ctl),
        .cls    (main_cls)
    );

    ctl_alu_dec u_alu (
        .cls   (main_cls),
        .funct (i_funct),
        .code  (alu_code),
        .legal (alu_legal)
    );

    assign gated_ctl    = alu_legal ? main_ctl : CTL_OFF;

    assign o_reg_dst    = gated_ctl.reg_dst;
    assign o_alu_src    = gated_ctl.alu_src;
    assign o_mem_to_reg = gated_ctl.mem_to_reg;
    assign o_reg_wr     = gated_ctl.reg_wr;
    assign o_mem_rd     = gated_ctl.mem_rd;
    assign o_mem_wr     = gated_ctl.mem_wr;
    assign o_branch     = gated_ctl.branch;
    assign o_alu_cls    = main_cls;
    assign o_alu_code   = alu_code;

endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk (
    input logic [5:0] opcode,
    input logic [5:0] funct,
    input logic       reg_dst,
    input logic       alu_src,
    input logic       mem_to_reg,
    input logic       reg_wr,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       branch,
    input logic [1:0] alu_cls,
    input logic [3:0] alu_code
);

    logic supported_op;
    logic any_en;

    assign supported_op = (opcode == 6'h00) || (opcode == 6'h23) ||
                          (opcode == 6'h2B) || (opcode == 6'h04);
    assign any_en = reg_dst | alu_src | mem_to_reg | reg_wr |
                    mem_rd | mem_wr | branch;

    always_comb begin
        p_mem_excl_r10: assert ($countones({mem_rd, mem_wr, branch}) <= 1 &&
                                !(reg_wr && mem_wr))
            else $error("R10 exclusive enables violated");

        if (!supported_op) begin
            p_unsup_off_r6: assert (!any_en && alu_cls == 2'b11 && alu_code == 4'b0000)
                else $error("R6 unsupported opcode not suppressed");
        end

        if (any_en) begin
            p_code_bit2_r9: assert (alu_code[2] == (alu_cls[0] | (alu_cls[1] & funct[1])))
                else $error("R9 code bit 2 mismatch");
        end

        if (branch) begin
            p_branch_sub_r4: assert (opcode == 6'h04 && alu_cls == 2'b01 &&
                                     alu_code == 4'b0110 && !reg_wr)
                else $error("R4 branch decode wrong");
        end

        if (mem_rd) begin
            p_load_path_r2: assert (mem_to_reg && reg_wr && alu_src && !reg_dst &&
                                    alu_code == 4'b0010)
                else $error("R2 load decode wrong");
        end

        if (opcode == 6'h00 && !any_en) begin
            p_rtype_kill_r7: assert (alu_code == 4'b0000 && alu_cls == 2'b10)
                else $error("R7 suppressed register op wrong");
        end
    end

endmodule

bind ctl_decoder_top ctl_decoder_chk u_chk (
    .opcode     (i_opcode),
    .funct      (i_funct),
    .reg_dst    (o_reg_dst),
    .alu_src    (o_alu_src),
    .mem_to_reg (o_mem_to_reg),
    .reg_wr     (o_reg_wr),
    .mem_rd     (o_mem_rd),
    .mem_wr     (o_mem_wr),
    .branch     (o_branch),
    .alu_cls    (o_alu_cls),
    .alu_code   (o_alu_code)
);

// File: tb/ctl_decoder_top_tb.sv
module ctl_decoder_top_tb;

    logic       clk = 1'b0;
    logic [5:0] opcode;
    logic [5:0] funct;
    logic       reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch;
    logic [1:0] alu_cls;
    logic [3:0] alu_code;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    ctl_decoder_top u_dut (
        .i_opcode     (opcode),
        .i_funct      (funct),
        .o_reg_dst    (reg_dst),
        .o_alu_src    (alu_src),
        .o_mem_to_reg (mem_to_reg),
        .o_reg_wr     (reg_wr),
        .o_mem_rd     (mem_rd),
        .o_mem_wr     (mem_wr),
        .o_branch     (branch),
        .o_alu_cls    (alu_cls),
        .o_alu_code   (alu_code)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s op=%02h fn=%02h actual=%h expected=%h", req, opcode, funct, act, exp);
        end
    endtask

    function automatic logic [3:0] fn_to_code(input logic [5:0] f, output logic ok);
        ok = 1'b1;
        case (f)
            6'h20: return 4'b0010;
            6'h22: return 4'b0110;
            6'h24: return 4'b0000;
            6'h25: return 4'b0001;
            6'h2A: return 4'b0111;
            default: begin ok = 1'b0; return 4'b0000; end
        endcase
    endfunction

    task automatic sweep_one(input logic [5:0] op, input logic [5:0] fn);
        logic [6:0] e_ctl;
        logic [1:0] e_cls;
        logic [3:0] e_code;
        logic       ok;
        logic [3:0] fc;
        string      req;
        @(negedge clk);
        opcode = op;
        funct  = fn;
        #1;
        // e_ctl order: reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch
        fc = fn_to_code(fn, ok);
        case (op)
            6'h00: begin
                e_cls = 2'b10;
                if (ok) begin e_ctl = 7'b1001000; e_code = fc; req = "R1/R5"; end
                else    begin e_ctl = 7'b0000000; e_code = 4'b0000; req = "R7"; end
            end
            6'h23: begin e_ctl = 7'b0111100; e_cls = 2'b00; e_code = 4'b0010; req = "R2/R8"; end
            6'h2B: begin e_ctl = 7'b0100010; e_cls = 2'b00; e_code = 4'b0010; req = "R3/R8"; end
            6'h04: begin e_ctl = 7'b0000001; e_cls = 2'b01; e_code = 4'b0110; req = "R4/R8"; end
            default: begin e_ctl = 7'b0000000; e_cls = 2'b11; e_code = 4'b0000; req = "R6/R8"; end
        endcase
        check({req, " ctl"}, {9'd0, reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch},
              {9'd0, e_ctl});
        check({req, " cls"}, {14'd0, alu_cls}, {14'd0, e_cls});
        check({req, " code"}, {12'd0, alu_code}, {12'd0, e_code});
        if (e_ctl != 7'd0)
            check("R9 bit2", {15'd0, alu_code[2]}, {15'd0, e_cls[0] | (e_cls[1] & fn[1])});
        check("R10 excl", {15'd0, ($countones({mem_rd, mem_wr, branch}) > 1) || (reg_wr && mem_wr)},
              16'd0);
    endtask

    initial begin
        opcode = 6'h00;
        funct  = 6'h00;
        #1;
        // Initial state: opcode 0, funct 0 is an unknown register-format op (R7)
        check("R7 initial ctl", {9'd0, reg_dst, alu_src, mem_to_reg, reg_wr, mem_rd, mem_wr, branch}, 16'd0);
        check("R7 initial code", {12'd0, alu_code}, 16'd0);
        for (int op = 0; op < 64; op++) begin
            for (int fn = 0; fn < 64; fn++) begin
                sweep_one(op[5:0], fn[5:0]);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule